// File: doc/BRIEF.md
# Operand-to-address forwarding bus sequencer

This block is the bus front end of a small processor with an 8-bit data bus and a 16-bit address bus. It steps through the bus cycles of four instruction shapes: a page-zero load, a page-zero load with an index added, an absolute jump, and a load through a pointer held in page zero. For every bus cycle it drives the memory address and a read strobe. When a data read completes, it returns the loaded byte. Each bus cycle has two halves, set by the phase-2 strobe. The address and the sequencer state move only at the clock edge that closes a phase-2-high half, so the address is steady during phase-2 low. Data is taken from the bus while phase 2 is high.

The key property is forwarding. A byte captured from the data bus at the end of one cycle can form the address of the very next cycle. This is possible because only one register lies on that path, the data latch, followed by an address multiplexer. A dead cycle is inserted only when the captured byte needs arithmetic first, which here means the index add.

Top module: `bus_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer returns to opcode fetch. After reset, `addr` equals `rst_vec`, `rd` is 1 and `ld_valid` is 0.
- R2: The data latch and `addr` update only at a clock edge where `phi2` is 1. While `phi2` is held low for any number of clocks, `addr` and the captured data stay unchanged and no load is reported.
- R3: Opcode 0x11 (page-zero load) takes three bus cycles: opcode at PC, operand at PC+1, then a read at `{8'h00, operand}`. No cycle is inserted between the operand fetch and the read.
- R4: Opcode 0x12 (indexed page-zero load) uses four cycles: opcode, operand, one dead cycle with `rd` = 0, then a read at `{8'h00, (operand + x_idx) mod 256}`.
- R5: Opcode 0x13 (indirect load) uses five cycles: opcode, operand P, a read at `{8'h00, P}` giving the low byte L, a read at `{8'h00, (P+1) mod 256}` giving the high byte H, then a read at `{H, L}`.
- R6: Opcode 0x20 (jump) reads the low byte T0 at PC+1 and the high byte T1 at PC+2. The very next cycle is an opcode fetch at `{T1, T0}`, and the following fetch continues at `{T1, T0}+1`.
- R7: The PC advances by one for each opcode or operand fetch and does not advance for data reads or the dead cycle. The next opcode after a load is fetched from the byte that follows the last operand.
- R8: Any other opcode is a one-cycle no-op: the next cycle fetches an opcode at PC+1 and no load is reported.
- R9: After the final read of a load, `ld_valid` is high for exactly one clock and `ld_val` holds the byte that `din` carried at the end of that read cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | Phase-2 strobe; high marks the data half of a bus cycle |
| din | input | 8 | Data bus in |
| x_idx | input | 8 | Index value added in the indexed load |
| rst_vec | input | 16 | PC value loaded at reset |
| addr | output | 16 | Bus address for the current cycle |
| rd | output | 1 | High when the current cycle reads |
| ld_val | output | 8 | Byte returned by the last completed load |
| ld_valid | output | 1 | One-clock pulse when `ld_val` is new |

## Verification
At one edge, the byte arriving on `din` is both captured as data and selected as the next cycle's address. This happens after the page-zero operand fetch, after the pointer high-byte read, and after the jump high-byte fetch. The bench drives a memory model whose contents make each forwarded address unique, so a cycle of lag or a stale byte shows up as a wrong address. It checks every bus cycle's address in the phase-2-high half. The indirect pointer at 0xFF and the index sum past 0xFF exercise the page-zero wrap in the same cycles.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [3:0] {
        ST_OP,
        ST_OP_JMP,
        ST_ZP_OPR,
        ST_RD_ZP,
        ST_ZPX_OPR,
        ST_ZPX_DEAD,
        ST_RD_SUM,
        ST_IND_OPR,
        ST_PTR_LO,
        ST_PTR_HI,
        ST_RD_IND,
        ST_JMP_LO,
        ST_JMP_HI
    } seq_state_e;

    typedef enum logic [2:0] {
        SEL_PC,
        SEL_PAGE0_DL,
        SEL_PAGE0_TMP,
        SEL_PAGE0_TMP_INC,
        SEL_DL_TMP
    } addr_sel_e;

    typedef struct packed {
        addr_sel_e sel;
        logic      rd;
        logic      data_rd;
    } bus_ctl_t;

    localparam logic [7:0] OPC_LD_PAGE0  = 8'h11;
    localparam logic [7:0] OPC_LD_INDEX  = 8'h12;
    localparam logic [7:0] OPC_LD_PTR    = 8'h13;
    localparam logic [7:0] OPC_JUMP      = 8'h20;

    function automatic seq_state_e decode_op(input logic [7:0] opc);
        seq_state_e nxt;
        case (opc)
            OPC_LD_PAGE0: nxt = ST_ZP_OPR;
            OPC_LD_INDEX: nxt = ST_ZPX_OPR;
            OPC_LD_PTR:   nxt = ST_IND_OPR;
            OPC_JUMP:     nxt = ST_JMP_LO;
            default:      nxt = ST_OP;
        endcase
        return nxt;
    endfunction

    function automatic bus_ctl_t ctl_of(input seq_state_e st);
        bus_ctl_t c;
        c = '{sel: SEL_PC, rd: 1'b1, data_rd: 1'b0};
        case (st)
            ST_OP_JMP:   c.sel = SEL_DL_TMP;
            ST_RD_ZP:    begin c.sel = SEL_PAGE0_DL;  c.data_rd = 1'b1; end
            ST_ZPX_DEAD: c.rd = 1'b0;
            ST_RD_SUM:   begin c.sel = SEL_PAGE0_TMP; c.data_rd = 1'b1; end
            ST_PTR_LO:   c.sel = SEL_PAGE0_DL;
            ST_PTR_HI:   c.sel = SEL_PAGE0_TMP_INC;
            ST_RD_IND:   begin c.sel = SEL_DL_TMP;    c.data_rd = 1'b1; end
            default:     c.sel = SEL_PC;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bseq_dlatch.sv
module bseq_dlatch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          phi2,
    input  logic [DW-1:0] din,
    input  logic          capture,
    output logic [DW-1:0] dl,
    output logic [DW-1:0] ld_val,
    output logic          ld_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dl       <= '0;
            ld_val   <= '0;
            ld_valid <= 1'b0;
        end else begin
            ld_valid <= 1'b0;
            if (phi2) begin
                dl <= din;
                if (capture) begin
                    ld_val   <= din;
                    ld_valid <= 1'b1;
                end
            end
        end
    end

    // R2: the captured byte holds across a phase-2-low clock
    p_dl_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!phi2 && !$past(rst)) |=> $stable(dl));

    // R9: the load pulse lasts one clock
    p_ldv_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> !ld_valid);

    // R9: the reported byte is what the bus carried at the closing edge
    p_ld_value_r9: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !$past(rst)) |-> (ld_val == $past(din)));

endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import bseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          phi2,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] dl,
    input  logic [DW-1:0] x_idx,
    input  logic [AW-1:0] rst_vec,
    output seq_state_e    st,
    output bus_ctl_t      ctl,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] tmp
);

    seq_state_e    st_nxt;
    logic [AW-1:0] pc_nxt;
    logic [DW-1:0] tmp_nxt;
    logic [AW-1:0] jmp_tgt;
    logic [AW-1:0] pc_inc;

    assign ctl     = ctl_of(st);
    assign jmp_tgt = AW'({dl, tmp});
    assign pc_inc  = pc + AW'(1);

    always_comb begin
        st_nxt  = st;
        pc_nxt  = pc;
        tmp_nxt = tmp;
        case (st)
            ST_OP:       begin st_nxt = decode_op(din[7:0]); pc_nxt = pc_inc; end
            ST_OP_JMP:   begin st_nxt = decode_op(din[7:0]); pc_nxt = jmp_tgt + AW'(1); end
            ST_ZP_OPR:   begin st_nxt = ST_RD_ZP;    pc_nxt = pc_inc; end
            ST_ZPX_OPR:  begin st_nxt = ST_ZPX_DEAD; pc_nxt = pc_inc; end
            ST_ZPX_DEAD: begin st_nxt = ST_RD_SUM;   tmp_nxt = dl + x_idx; end
            ST_IND_OPR:  begin st_nxt = ST_PTR_LO;   pc_nxt = pc_inc; tmp_nxt = din; end
            ST_PTR_LO:   st_nxt = ST_PTR_HI;
            ST_PTR_HI:   begin st_nxt = ST_RD_IND;   tmp_nxt = dl; end
            ST_JMP_LO:   begin st_nxt = ST_JMP_HI;   pc_nxt = pc_inc; tmp_nxt = din; end
            ST_JMP_HI:   begin st_nxt = ST_OP_JMP;   pc_nxt = pc_inc; end
            default:     st_nxt = ST_OP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_OP;
            pc  <= rst_vec;
            tmp <= '0;
        end else if (phi2) begin
            st  <= st_nxt;
            pc  <= pc_nxt;
            tmp <= tmp_nxt;
        end
    end

    // R4: the dead cycle leaves the wrapped sum of operand and index
    p_index_sum_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_ZPX_DEAD && $past(phi2) && !$past(rst))
        |-> (tmp == DW'($past(dl) + $past(x_idx))));

    // R4: the operand fetch of an indexed load is followed by a dead cycle
    p_dead_follows_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_ZPX_OPR && $past(phi2) && !$past(rst))
        |-> (st == ST_ZPX_DEAD));

    // R7: data reads leave the program counter alone
    p_pc_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (phi2 && ctl.data_rd) |=> $stable(pc));

endmodule

// File: rtl/bseq_addr_mux.sv
module bseq_addr_mux
    import bseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  bus_ctl_t      ctl,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] dl,
    input  logic [DW-1:0] tmp,
    output logic [AW-1:0] addr,
    output logic          rd
);

    localparam int PW = AW - DW;

    logic [DW-1:0] tmp_inc;
    assign tmp_inc = tmp + DW'(1);

    always_comb begin
        case (ctl.sel)
            SEL_PAGE0_DL:      addr = {{PW{1'b0}}, dl};
            SEL_PAGE0_TMP:     addr = {{PW{1'b0}}, tmp};
            SEL_PAGE0_TMP_INC: addr = {{PW{1'b0}}, tmp_inc};
            SEL_DL_TMP:        addr = AW'({dl, tmp});
            default:           addr = pc;
        endcase
    end

    assign rd = ctl.rd;

endmodule

// File: rtl/bus_seq.sv
module bus_seq
    import bseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          phi2,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] x_idx,
    input  logic [AW-1:0] rst_vec,
    output logic [AW-1:0] addr,
    output logic          rd,
    output logic [DW-1:0] ld_val,
    output logic          ld_valid
);

    localparam int PW = AW - DW;

    seq_state_e    st;
    bus_ctl_t      ctl;
    logic [AW-1:0] pc;
    logic [DW-1:0] tmp;
    logic [DW-1:0] dl;

    bseq_dlatch #(.DW(DW)) u_dlatch (
        .clk      (clk),
        .rst      (rst),
        .phi2     (phi2),
        .din      (din),
        .capture  (ctl.data_rd),
        .dl       (dl),
        .ld_val   (ld_val),
        .ld_valid (ld_valid)
    );

    bseq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .phi2    (phi2),
        .din     (din),
        .dl      (dl),
        .x_idx   (x_idx),
        .rst_vec (rst_vec),
        .st      (st),
        .ctl     (ctl),
        .pc      (pc),
        .tmp     (tmp)
    );

    bseq_addr_mux #(.AW(AW), .DW(DW)) u_amux (
        .ctl  (ctl),
        .pc   (pc),
        .dl   (dl),
        .tmp  (tmp),
        .addr (addr),
        .rd   (rd)
    );

    // R2: the address never moves at an edge closing a phase-2-low clock
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(phi2) && !$past(rst)) |-> $stable(addr));

    // R3: the page-zero operand becomes the next address with no extra stage
    p_zp_forward_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_ZP_OPR && $past(phi2) && !$past(rst))
        |-> (addr == {{PW{1'b0}}, $past(din)}));

    // R5: the pointer high byte is forwarded next to the stored low byte
    p_ptr_forward_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_PTR_HI && $past(phi2) && !$past(rst))
        |-> (addr == AW'({$past(din), $past(dl)})));

    // R6: the jump target drives the very next opcode fetch
    p_jump_forward_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_JMP_HI && $past(phi2) && !$past(rst))
        |-> (addr == AW'({$past(din), $past(tmp)})));

endmodule

// File: tb/bus_seq_bench.sv
module bus_seq_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phi2 = 1'b0;
    logic [7:0]  din;
    logic [7:0]  x_idx = 8'h20;
    logic [15:0] rst_vec = 16'h0300;
    logic [15:0] addr;
    logic        rd;
    logic [7:0]  ld_val;
    logic        ld_valid;

    logic [7:0]  mem [0:1023];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    logic [15:0] s_addr;
    logic        s_rd;
    logic        s_lv;
    logic [7:0]  s_lval;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign din = mem[addr[9:0]];

    bus_seq u_bus_seq (
        .clk      (clk),
        .rst      (rst),
        .phi2     (phi2),
        .din      (din),
        .x_idx    (x_idx),
        .rst_vec  (rst_vec),
        .addr     (addr),
        .rd       (rd),
        .ld_val   (ld_val),
        .ld_valid (ld_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // one bus cycle: low half, high half, sample mid-high, then the closing edge
    task automatic tick();
        @(negedge clk); phi2 = 1'b0;
        @(negedge clk); phi2 = 1'b1;
        #1;
        s_addr = addr;
        s_rd   = rd;
        @(posedge clk); #2;
        s_lv   = ld_valid;
        s_lval = ld_val;
    endtask

    task automatic cyc(input logic [15:0] ea, input bit care_a, input bit er, input string req);
        tick();
        if (care_a) chk(s_addr == ea, req, s_addr, ea);
        chk(s_rd == er, req, 16'(s_rd), 16'(er));
    endtask

    task automatic no_load(input string req);
        chk(s_lv == 1'b0, req, 16'(s_lv), 16'h0);
    endtask

    task automatic got_load(input logic [7:0] v, input string req);
        chk(s_lv == 1'b1, req, 16'(s_lv), 16'h1);
        chk(s_lval == v, req, 16'(s_lval), 16'(v));
    endtask

    task automatic t_reset();
        rst = 1'b1; phi2 = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(addr == rst_vec, "R1 reset address", addr, rst_vec);
        chk(rd == 1'b1, "R1 reset rd", 16'(rd), 16'h1);
        chk(ld_valid == 1'b0, "R1 reset ld_valid", 16'(ld_valid), 16'h0);
    endtask

    task automatic t_page0();
        cyc(16'h0300, 1, 1, "R3 opcode fetch");   no_load("R9 no load on fetch");
        cyc(16'h0301, 1, 1, "R3 operand fetch");
        cyc(16'h0040, 1, 1, "R3 forwarded read"); got_load(8'h5A, "R9 page-zero value");
    endtask

    task automatic t_indexed();
        cyc(16'h0302, 1, 1, "R7 next opcode after load");
        cyc(16'h0303, 1, 1, "R4 operand fetch");
        cyc(16'h0000, 0, 0, "R4 dead cycle rd low"); no_load("R9 dead cycle no load");
        cyc(16'h0010, 1, 1, "R4 wrapped sum read"); got_load(8'hC3, "R9 indexed value");
    endtask

    task automatic t_indirect();
        cyc(16'h0304, 1, 1, "R7 opcode after indexed load");
        cyc(16'h0305, 1, 1, "R5 operand fetch");
        cyc(16'h00FF, 1, 1, "R5 pointer low read"); no_load("R9 pointer read not a load");
        cyc(16'h0000, 1, 1, "R5 pointer high wraps");
        cyc(16'h0280, 1, 1, "R5 read through pointer"); got_load(8'h77, "R9 indirect value");
    endtask

    task automatic t_hold();
        logic [15:0] held;
        held = addr;
        phi2 = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(addr == held, "R2 address held while phi2 low", addr, held);
        end
        chk(ld_valid == 1'b0, "R2 no load while phi2 low", 16'(ld_valid), 16'h0);
    endtask

    task automatic t_unknown();
        cyc(16'h0306, 1, 1, "R8 unknown opcode fetch"); no_load("R8 no load");
        cyc(16'h0307, 1, 1, "R8 next fetch at PC+1");
    endtask

    task automatic t_jump();
        cyc(16'h0308, 1, 1, "R6 target low fetch");
        cyc(16'h0309, 1, 1, "R6 target high fetch");
        cyc(16'h0390, 1, 1, "R6 opcode at target");
        cyc(16'h0391, 1, 1, "R6 PC continues after target");
        cyc(16'h0041, 1, 1, "R3 read after jump"); got_load(8'h6B, "R9 value after jump");
        cyc(16'h0392, 1, 1, "R7 opcode after load");
    endtask

    task automatic t_reset_mid();
        cyc(16'h0393, 1, 1, "R8 zero opcode is no-op");
        @(negedge clk); rst = 1'b1; phi2 = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0; phi2 = 1'b0;
        #1;
        chk(addr == rst_vec, "R1 reset mid-run", addr, rst_vec);
        chk(ld_valid == 1'b0, "R1 ld_valid cleared", 16'(ld_valid), 16'h0);
        cyc(16'h0300, 1, 1, "R1 restart fetch");
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        mem[16'h0300] = 8'h11; mem[16'h0301] = 8'h40;
        mem[16'h0302] = 8'h12; mem[16'h0303] = 8'hF0;
        mem[16'h0304] = 8'h13; mem[16'h0305] = 8'hFF;
        mem[16'h0306] = 8'hEE;
        mem[16'h0307] = 8'h20; mem[16'h0308] = 8'h90; mem[16'h0309] = 8'h03;
        mem[16'h0390] = 8'h11; mem[16'h0391] = 8'h41;
        mem[16'h0040] = 8'h5A; mem[16'h0041] = 8'h6B;
        mem[16'h0010] = 8'hC3;
        mem[16'h00FF] = 8'h80; mem[16'h0000] = 8'h02;
        mem[16'h0280] = 8'h77;

        t_reset();
        t_page0();
        t_indexed();
        t_indirect();
        t_hold();
        t_unknown();
        t_jump();
        t_reset_mid();
        done = 1'b1;
        summary();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

endmodule